// File: doc/BRIEF.md
# Cache-side performance counter bank

This block keeps a set of event counters and one free-running cycle counter for a cache, all read and written through a word-addressed register port. Every event counter is 32 bits wide. The cycle counter is 64 bits wide. The number of event counters, `NUM_EVT`, is a parameter from 1 to 31. Each counter has a one-cycle increment strobe. It counts only when the global enable is on and its own enable bit is on.

Three masks control the counters: counter enable, interrupt enable and overflow status. Each mask has two addresses, one that sets bits and one that clears bits. In all three masks, event counter i owns bit i and the cycle counter owns bit 31. A counter that wraps from all-ones to zero sets its overflow bit. The interrupt output is a level signal. It stays high while any overflow bit is set whose interrupt enable is also set.

Software acknowledges an overflow in two steps. It reads the status, then writes the same value to the clear address.

Top module: `pmu_counter_bank`

## Requirements
- R1: After reset, all counters hold zero, all three masks and the global enable are zero, and `irq` is low.
- R2: Address 0x400 reads the global enable in bit 0 and `NUM_EVT` in bits 15:11. All other bits read zero. A write to 0x400 loads bit 0 into the global enable.
- R3: A write to 0x400 with bit 1 set clears every event counter. A write with bit 2 set clears the cycle counter, so the value 0x6 clears all counters. The clear takes priority over an increment in the same cycle.
- R4: Event counter i adds one on a cycle where `evt_inc[i]` is high only if the global enable is set and enable bit i is set. The cycle counter does the same with `cyc_tick` and enable bit 31. In every other cycle a counter holds its value.
- R5: Counter enable is set at 0x404 and cleared at 0x403. Interrupt enable is set at 0x406 and cleared at 0x405. Each bit written as one sets or clears only that bit. Either address of a pair reads the current mask.
- R6: In every mask, bit i belongs to event counter i and bit 31 to the cycle counter. Bits that belong to no counter always read zero and cannot be set.
- R7: Event counter i is read and written at 0x421 + 0x10*i, using the low 32 bits, and reads back zero-extended. The cycle counter is read and written at 0x40A as 64 bits. A write preloads the counter. If a write and an increment hit the same counter in one cycle, the written value is kept.
- R8: An increment from all-ones wraps the counter to zero and sets its overflow bit. The overflow mask is read at 0x408 or 0x407. Writing ones at 0x408 sets bits and writing ones at 0x407 clears bits. If a wrap and a clear hit the same bit in one cycle, the bit ends up set.
- R9: `irq` is high exactly when some bit is set in both the overflow mask and the interrupt-enable mask. It stays high until that condition ends.
- R10: Reads of any other address return zero. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the current address |
| reg_addr | input | ADDR_W | Word address for reads and writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| evt_inc | input | NUM_EVT | One-cycle increment strobes for the event counters |
| cyc_tick | input | 1 | Increment strobe for the cycle counter |
| irq | output | 1 | Level overflow interrupt |

## Verification
Every piece of state can be read back at the port. A wrong counter, enable or status bit therefore shows up at `reg_rdata` on the first read of its address after the faulty edge. A status or interrupt-enable fault also changes `irq` in the same cycle. Some faults stay hidden until a counter approaches all-ones: a wrong wrap, a lost gate or a misplaced mask bit first becomes visible when the overflow bit fails to set, or is set in the wrong position. For that reason the stimulus often preloads counters just below the wrap point. This means a fault in the overflow path is visible within a few cycles rather than after 2^32 increments.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int CTRL_A     = 'h400;
   localparam int EN_CLR_A   = 'h403;
   localparam int EN_SET_A   = 'h404;
   localparam int IE_CLR_A   = 'h405;
   localparam int IE_SET_A   = 'h406;
   localparam int OV_CLR_A   = 'h407;
   localparam int OV_SET_A   = 'h408;
   localparam int CYC_A      = 'h40A;
   localparam int EVT_BASE_A = 'h421;
   localparam int EVT_STRIDE = 'h10;
   localparam int CYC_BIT    = 31;
   localparam int CNT_FLD_LO = 11;
   localparam int EVT_W      = 32;
   localparam int CYC_W      = 64;
   localparam int MASK_W     = 32;

   function automatic int evt_addr(input int idx);
      return EVT_BASE_A + EVT_STRIDE * idx;
   endfunction

   function automatic logic [MASK_W-1:0] present_mask(input int n);
      logic [MASK_W-1:0] m;
      m = '0;
      for (int k = 0; k < n; k++) m[k] = 1'b1;
      m[CYC_BIT] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic             step,
   output logic [WIDTH-1:0] value,
   output logic             wrap
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("pmu_counter: WIDTH must be at least 2");
      end
   endgenerate

   assign wrap = step && !load && !clr && (&value);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     value <= '0;
      else if (load)  value <= load_val;
      else if (clr)   value <= '0;
      else if (step)  value <= value + WIDTH'(1);
   end
endmodule

// File: rtl/pmu_mask_reg.sv
module pmu_mask_reg #(
   parameter int          WIDTH   = 32,
   parameter logic [31:0] PRESENT = 32'hFFFF_FFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] hw_set,
   output logic [WIDTH-1:0] q
);
   localparam logic [WIDTH-1:0] KEEP = PRESENT[WIDTH-1:0];

   logic [WIDTH-1:0] sw_set, sw_clr, nxt;

   assign sw_set = set_we ? wdata : '0;
   assign sw_clr = clr_we ? wdata : '0;
   assign nxt    = (((q | sw_set) & ~sw_clr) | hw_set) & KEEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank
   import pmu_pkg::*;
#(
   parameter int NUM_EVT = 4,
   parameter int ADDR_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   input  logic [NUM_EVT-1:0] evt_inc,
   input  logic              cyc_tick,
   output logic              irq
);
   localparam logic [MASK_W-1:0] PRESENT = present_mask(NUM_EVT);
   localparam int LAST_A = EVT_BASE_A + EVT_STRIDE * (NUM_EVT - 1);

   generate
      if (NUM_EVT < 1 || NUM_EVT > 31) begin : g_bad_num
         $error("pmu_counter_bank: NUM_EVT must lie in 1..31");
      end
      if ((1 << ADDR_W) <= LAST_A) begin : g_bad_addr
         $error("pmu_counter_bank: ADDR_W too narrow for the counter map");
      end
   endgenerate

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
      return a == ADDR_W'(target);
   endfunction

   logic              gen_q;
   logic              wr_ctrl, clr_evt, clr_cyc;
   logic [MASK_W-1:0] en_q, ie_q, ov_q, hw_ovf;
   logic [EVT_W-1:0]  evt_val [NUM_EVT];
   logic [NUM_EVT-1:0] evt_wrap;
   logic [CYC_W-1:0]  cyc_q;
   logic              cyc_wrap, cyc_load;

   assign wr_ctrl  = reg_wr && hit(reg_addr, CTRL_A);
   assign clr_evt  = wr_ctrl && reg_wdata[1];
   assign clr_cyc  = wr_ctrl && reg_wdata[2];
   assign cyc_load = reg_wr && hit(reg_addr, CYC_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gen_q <= 1'b0;
      else if (wr_ctrl) gen_q <= reg_wdata[0];
   end

   // event counters
   generate
      for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
         logic ld, stp;
         assign ld  = reg_wr && hit(reg_addr, evt_addr(gi));
         assign stp = gen_q && en_q[gi] && evt_inc[gi];
         pmu_counter #(.WIDTH(EVT_W)) i_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr_evt),
            .load    (ld),
            .load_val(reg_wdata[EVT_W-1:0]),
            .step    (stp),
            .value   (evt_val[gi]),
            .wrap    (evt_wrap[gi])
         );
      end
   endgenerate

   pmu_counter #(.WIDTH(CYC_W)) i_cyc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_cyc),
      .load    (cyc_load),
      .load_val(reg_wdata[CYC_W-1:0]),
      .step    (gen_q && en_q[CYC_BIT] && cyc_tick),
      .value   (cyc_q),
      .wrap    (cyc_wrap)
   );

   always_comb begin
      hw_ovf = '0;
      hw_ovf[NUM_EVT-1:0] = evt_wrap;
      hw_ovf[CYC_BIT] = cyc_wrap;
   end

   pmu_mask_reg #(.WIDTH(MASK_W), .PRESENT(PRESENT)) i_en (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_wr && hit(reg_addr, EN_SET_A)),
      .clr_we(reg_wr && hit(reg_addr, EN_CLR_A)),
      .wdata(reg_wdata[MASK_W-1:0]), .hw_set('0), .q(en_q)
   );

   pmu_mask_reg #(.WIDTH(MASK_W), .PRESENT(PRESENT)) i_ie (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_wr && hit(reg_addr, IE_SET_A)),
      .clr_we(reg_wr && hit(reg_addr, IE_CLR_A)),
      .wdata(reg_wdata[MASK_W-1:0]), .hw_set('0), .q(ie_q)
   );

   pmu_mask_reg #(.WIDTH(MASK_W), .PRESENT(PRESENT)) i_ov (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_wr && hit(reg_addr, OV_SET_A)),
      .clr_we(reg_wr && hit(reg_addr, OV_CLR_A)),
      .wdata(reg_wdata[MASK_W-1:0]), .hw_set(hw_ovf), .q(ov_q)
   );

   assign irq = |(ov_q & ie_q);

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (hit(reg_addr, CTRL_A)) begin
         reg_rdata[0] = gen_q;
         reg_rdata[CNT_FLD_LO +: 5] = 5'(NUM_EVT);
      end
      if (hit(reg_addr, EN_SET_A) || hit(reg_addr, EN_CLR_A)) reg_rdata[MASK_W-1:0] = en_q;
      if (hit(reg_addr, IE_SET_A) || hit(reg_addr, IE_CLR_A)) reg_rdata[MASK_W-1:0] = ie_q;
      if (hit(reg_addr, OV_SET_A) || hit(reg_addr, OV_CLR_A)) reg_rdata[MASK_W-1:0] = ov_q;
      if (hit(reg_addr, CYC_A)) reg_rdata = cyc_q;
      for (int k = 0; k < NUM_EVT; k++) begin
         if (hit(reg_addr, evt_addr(k))) reg_rdata[EVT_W-1:0] = evt_val[k];
      end
   end
endmodule

// File: rtl/pmu_bank_chk.sv
module pmu_bank_chk
   import pmu_pkg::*;
#(
   parameter int NUM_EVT = 4,
   parameter int ADDR_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [63:0]       reg_wdata,
   input logic              cyc_tick,
   input logic              irq,
   input logic              gen_q,
   input logic [31:0]       en_q,
   input logic [31:0]       ie_q,
   input logic [31:0]       ov_q,
   input logic [63:0]       cyc_q
);
   localparam logic [31:0] PRESENT = present_mask(NUM_EVT);

   // R4
   cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_q && !reg_wr) |=> $stable(cyc_q));

   // R3
   cyc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(CTRL_A) && reg_wdata[2]) |=> (cyc_q == '0));

   // R7
   cyc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(CYC_A)) |=> (cyc_q == $past(reg_wdata)));

   // R6
   mask_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_q | ie_q | ov_q) & ~PRESENT) == '0);

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_q[CYC_BIT] && !(reg_wr && reg_addr == ADDR_W'(OV_CLR_A))) |=> ov_q[CYC_BIT]);

   // R9
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !reg_wr) |=> irq);

   // R9
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_q == '0) |-> !irq);

   // R4
   cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_q && en_q[CYC_BIT] && cyc_tick && !reg_wr) |=> (cyc_q == $past(cyc_q) + 64'd1));
endmodule

bind pmu_counter_bank pmu_bank_chk #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .cyc_tick(cyc_tick), .irq(irq), .gen_q(gen_q),
   .en_q(en_q), .ie_q(ie_q), .ov_q(ov_q), .cyc_q(cyc_q)
);

// File: tb/test_pmu_counter_bank.sv
module test_pmu_counter_bank;
   localparam int N = 4;
   localparam int AW = 12;
   localparam logic [31:0] P = 32'h8000_0000 | ((32'd1 << N) - 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [63:0]   reg_wdata = '0;
   logic [63:0]   reg_rdata;
   logic [N-1:0]  evt_inc = '0;
   logic          cyc_tick = 1'b0;
   logic          irq;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_evt [N];
   logic [63:0] m_cyc;
   logic [31:0] m_en, m_ie, m_ov;
   logic        m_gen;

   always #5 clk = ~clk;

   pmu_counter_bank #(.NUM_EVT(N), .ADDR_W(AW)) i_pmu_counter_bank (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_inc(evt_inc),
      .cyc_tick(cyc_tick), .irq(irq)
   );

   function automatic logic [AW-1:0] ea(input int i);
      return AW'(12'h421 + 12'h10 * i);
   endfunction

   function automatic logic [63:0] m_read(input logic [AW-1:0] a);
      logic [63:0] r = '0;
      case (a)
         12'h400: begin r[0] = m_gen; r[15:11] = 5'(N); end
         12'h403, 12'h404: r[31:0] = m_en;
         12'h405, 12'h406: r[31:0] = m_ie;
         12'h407, 12'h408: r[31:0] = m_ov;
         12'h40A: r = m_cyc;
         default: for (int i = 0; i < N; i++) if (a == ea(i)) r[31:0] = m_evt[i];
      endcase
      return r;
   endfunction

   task automatic m_step(input bit w, input logic [AW-1:0] a, input logic [63:0] d,
                         input logic [N-1:0] inc, input bit tk);
      logic [31:0] hw = '0;
      logic [31:0] dm = d[31:0];
      for (int i = 0; i < N; i++) begin
         if (w && a == ea(i)) m_evt[i] = d[31:0];
         else if (w && a == 12'h400 && d[1]) m_evt[i] = '0;
         else if (m_gen && m_en[i] && inc[i]) begin
            if (m_evt[i] == 32'hFFFF_FFFF) hw[i] = 1'b1;
            m_evt[i] = m_evt[i] + 32'd1;
         end
      end
      if (w && a == 12'h40A) m_cyc = d;
      else if (w && a == 12'h400 && d[2]) m_cyc = '0;
      else if (m_gen && m_en[31] && tk) begin
         if (m_cyc == '1) hw[31] = 1'b1;
         m_cyc = m_cyc + 64'd1;
      end
      if (w && a == 12'h404) m_en = (m_en | dm) & P;
      if (w && a == 12'h403) m_en = m_en & ~dm;
      if (w && a == 12'h406) m_ie = (m_ie | dm) & P;
      if (w && a == 12'h405) m_ie = m_ie & ~dm;
      m_ov = ((m_ov | ((w && a == 12'h408) ? dm : 32'd0)) & ~((w && a == 12'h407) ? dm : 32'd0) | hw) & P;
      if (w && a == 12'h400) m_gen = d[0];
   endtask

   task automatic cyc(input bit w, input logic [AW-1:0] a, input logic [63:0] d,
                      input logic [N-1:0] inc, input bit tk);
      reg_wr = w; reg_addr = a; reg_wdata = d; evt_inc = inc; cyc_tick = tk;
      @(posedge clk);
      m_step(w, a, d, inc, tk);
      @(negedge clk);
      reg_wr = 1'b0; evt_inc = '0; cyc_tick = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input string tag, input logic [AW-1:0] a);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, m_read(a));
      chk({tag, " irq"}, 64'(irq), 64'(|(m_ov & m_ie)));
   endtask

   task automatic rd_lit(input string tag, input logic [AW-1:0] a, input logic [63:0] exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [AW-1:0] addrs [12];
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) m_evt[i] = '0;
      m_cyc = '0; m_en = '0; m_ie = '0; m_ov = '0; m_gen = 1'b0;
      addrs = '{12'h400, 12'h403, 12'h404, 12'h405, 12'h406, 12'h407,
                12'h408, 12'h40A, 12'h421, 12'h431, 12'h451, 12'h402};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_lit("R1 ctrl", 12'h400, 64'(N) << 11);
      rd_lit("R1 en", 12'h404, 64'd0);
      rd_lit("R1 ovf", 12'h408, 64'd0);
      rd_lit("R1 cyc", 12'h40A, 64'd0);
      rd_lit("R1 evt0", 12'h421, 64'd0);
      chk("R1 irq", 64'(irq), 64'd0);

      // R4 gate: enable bit set but global off -> no count
      cyc(1, 12'h404, 64'h8000_0001, '0, 0);
      cyc(0, 12'h400, 0, 4'b0001, 1);
      rd_lit("R4 no global", 12'h421, 64'd0);
      cyc(1, 12'h400, 64'd1, '0, 0);
      rd_lit("R2 enable readback", 12'h400, (64'(N) << 11) | 64'd1);
      cyc(0, 12'h400, 0, 4'b0011, 1);
      rd_lit("R4 evt0 counts", 12'h421, 64'd1);
      rd_lit("R4 evt1 gated", 12'h431, 64'd0);
      rd_lit("R4 cyc counts", 12'h40A, 64'd1);

      // R6 unused bits
      cyc(1, 12'h404, 64'hFFFF_FFFF, '0, 0);
      rd_lit("R6 en mask", 12'h403, 64'(P));

      // R7 write wins, R8 wrap
      cyc(1, 12'h421, 64'hFFFF_FFFF, 4'b0001, 0);
      rd_lit("R7 write wins", 12'h421, 64'hFFFF_FFFF);
      cyc(0, 12'h400, 0, 4'b0001, 0);
      rd_lit("R8 wrap value", 12'h421, 64'd0);
      rd_lit("R8 ovf bit0", 12'h408, 64'd1);
      chk("R9 irq off without ie", 64'(irq), 64'd0);
      cyc(1, 12'h406, 64'h1, '0, 0);
      chk("R9 irq on", 64'(irq), 64'd1);
      cyc(1, 12'h40A, 64'hFFFF_FFFF_FFFF_FFFF, '0, 0);
      cyc(0, 12'h400, 0, '0, 1);
      rd_lit("R8 cyc ovf bit31", 12'h407, 64'h8000_0001);
      // R8 set wins over clear
      cyc(1, 12'h421, 64'hFFFF_FFFF, '0, 0);
      cyc(1, 12'h407, 64'h0000_0001, 4'b0001, 0);
      rd_lit("R8 set beats clear", 12'h408, 64'h8000_0001);
      cyc(1, 12'h407, 64'h8000_0001, '0, 0);
      rd_lit("R8 cleared", 12'h408, 64'd0);
      chk("R9 irq drops", 64'(irq), 64'd0);
      cyc(1, 12'h408, 64'h0000_0002, '0, 0);
      rd_lit("R8 sw set", 12'h408, 64'd2);

      // R10 unmapped
      cyc(1, 12'h402, 64'hFFFF_FFFF_FFFF_FFFF, '0, 0);
      rd_lit("R10 unmapped read", 12'h402, 64'd0);
      rd("R10 ctrl intact", 12'h400);
      rd("R10 en intact", 12'h404);

      // R3 reset-all beats increment
      cyc(1, 12'h400, 64'h7, 4'b1111, 1);
      rd_lit("R3 evt0 cleared", 12'h421, 64'd0);
      rd_lit("R3 cyc cleared", 12'h40A, 64'd0);
      rd_lit("R2 ctrl after 0x7", 12'h400, (64'(N) << 11) | 64'd1);

      // random mix R2 R3 R4 R5 R7 R8 R9
      for (int n = 0; n < 3000; n++) begin
         int op = $urandom_range(0, 15);
         logic [AW-1:0] a = addrs[$urandom_range(0, 11)];
         logic [63:0] d = {$urandom, $urandom};
         logic [N-1:0] inc = N'($urandom);
         bit tk = 1'($urandom);
         bit w = (op >= 6);
         if (a == 12'h400) d = ($urandom_range(0, 7) == 0) ? 64'(($urandom_range(0, 3)) << 1) | 64'd1 : 64'(d[0] | 1'b1) & (op[0] ? 64'h1 : 64'h0);
         if (a == 12'h40A && op[1]) d = 64'hFFFF_FFFF_FFFF_FFF0 | 64'(d[3:0]);
         if ((a == 12'h421 || a == 12'h431) && op[1]) d = 64'hFFFF_FFF0 | 64'(d[3:0]);
         cyc(w, a, d, inc, tk);
         rd("R5 R7 R8 random", addrs[$urandom_range(0, 11)]);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule